// File: doc/BRIEF.md
# Power-On Reset Sequencer with Delayed Reset Output

This block produces the chip-wide active-low reset and drives a reset output pin for neighbouring devices. It holds reset while any of three conditions is missing: the supply is good (above its 3.5 V threshold, given here as a digital flag), the oscillator is running, and the external active-low reset input is high. Once all three hold together, a counter clocked by the device clock times a fixed delay of about 5 ms. The internal reset and the reset output are then released on the same clock edge. If any condition drops while the delay is running, the delay starts again from zero.

Pulling the external reset input low forces reset at once, without waiting for a clock edge. Release from that reset still passes through a two-flop synchroniser. The supply and oscillator flags are synchronised the same way. A USB bus reset has no effect on any output. While reset is held, a float command tells the parallel FIFO pins and the serial configuration-memory pins to go high-impedance. The released reset-output level can drive the data-line pull-up, so attachment to the host is delayed until the device is ready.

The reset pin has three drive states. It is driven low while the external reset is low. It floats while waiting for the supply, the oscillator or the delay. It is driven high once reset is released. The delay length is the parameter `DELAY_US` combined with the clock frequency `CLK_HZ`.

Top module: `por_reset_seq`

## Requirements
- R1: While `ext_rst_n` is low, the outputs are `core_rst_n`=0, `rst_pin_oe`=1, `rst_pin_lvl`=0 and `if_float`=1. This takes effect immediately on the falling edge of `ext_rst_n`, with no clock edge needed.
- R2: When `ext_rst_n`, `supply_ok` and `osc_run` all become 1 together, `core_rst_n` goes to 1 on exactly the (DELAY_CYC+2)-th rising clock edge after the change. Here DELAY_CYC = (CLK_HZ/1000)*DELAY_US/1000, and the extra two edges are synchroniser latency.
- R3: If any one of the three release conditions stays 0, `core_rst_n` stays 0 for as long as that lasts, however long it is.
- R4: If `supply_ok` or `osc_run` drops for at least one clock during the delay, the delay restarts. Release then comes exactly DELAY_CYC+2 edges after the condition returns.
- R5: While `ext_rst_n` is 1 but reset is still held, `rst_pin_oe`=0, so the reset pin floats.
- R6: On release, `core_rst_n`=1, `rst_pin_oe`=1, `rst_pin_lvl`=1 and `if_float`=0, all from the same clock edge.
- R7: `usb_bus_rst` has no effect on any output, either while reset is held or after release.
- R8: If `supply_ok` or `osc_run` drops after release, reset is asserted again on the third rising edge after the drop. `if_float` goes to 1 and the reset pin floats.
- R9: Pulling `ext_rst_n` low after release asserts reset at once and drives the reset pin low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| ext_rst_n | input | 1 | External reset, active low, asserts asynchronously |
| supply_ok | input | 1 | Supply above release threshold |
| osc_run | input | 1 | Oscillator running |
| usb_bus_rst | input | 1 | USB bus reset indication (no effect) |
| core_rst_n | output | 1 | Internal reset, active low |
| rst_pin_lvl | output | 1 | Level for the reset output pin |
| rst_pin_oe | output | 1 | Output enable for the reset output pin |
| if_float | output | 1 | Tri-state command for FIFO and config-memory pins |

## Verification
The release path is tried in several ways, and each one isolates a different fault:
- A clean, simultaneous release of all three conditions shows whether the delay count is exactly right and whether the synchroniser depth is correct.
- Every single missing condition, held well past the delay, separates a correct three-way AND from one that ignores an input.
- Random drops at random points during the count, with random durations, show whether the counter truly restarts or merely pauses.
- Supply or oscillator loss after release checks the three-edge reassertion.

A USB bus reset is toggled at random throughout every phase, and a clock-free check of the outputs right after `ext_rst_n` falls confirms that the assertion is asynchronous.

// File: rtl/por_pkg.sv
package por_pkg;
  typedef enum logic {
    SEQ_HOLD = 1'b0,
    SEQ_LIVE = 1'b1
  } seq_state_e;
endpackage

// File: rtl/por_sync.sv
module por_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam int CHAIN_W = WIDTH * STAGES;

  logic [CHAIN_W-1:0] chain_q, chain_d;

  generate
    if (STAGES > 1) begin : g_multi
      always_comb chain_d = {chain_q[CHAIN_W-WIDTH-1:0], d};
    end else begin : g_single
      always_comb chain_d = d;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[CHAIN_W-1 -: WIDTH];
endmodule

// File: rtl/por_delay_cnt.sv
module por_delay_cnt #(
  parameter int LIMIT = 60000,
  parameter int W     = $clog2(LIMIT + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  output logic         done,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    done  = en && (cnt_q == LAST);
    cnt_d = (!en || done) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R4: a missing enable clears the count, so the next attempt starts from zero
  a_r4_cnt_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt_q == '0));
endmodule

// File: rtl/por_reset_seq.sv
module por_reset_seq
  import por_pkg::*;
#(
  parameter int CLK_HZ   = 12_000_000,
  parameter int DELAY_US = 5000
) (
  input  logic clk,
  input  logic ext_rst_n,
  input  logic supply_ok,
  input  logic osc_run,
  input  logic usb_bus_rst,
  output logic core_rst_n,
  output logic rst_pin_lvl,
  output logic rst_pin_oe,
  output logic if_float
);
  localparam longint DELAY_L   = (longint'(CLK_HZ) / 1000) * DELAY_US / 1000;
  localparam int     DELAY_CYC = (DELAY_L < 2) ? 2 : int'(DELAY_L);
  localparam int     CNT_W     = $clog2(DELAY_CYC + 1);

  logic [2:0]       raw_in, sync_out;
  logic             ext_s, sup_s, osc_s, cond_s;
  logic             dly_en, dly_done;
  logic [CNT_W-1:0] dly_cnt;
  seq_state_e       st_q, st_d;

  assign raw_in = {ext_rst_n, supply_ok, osc_run};

  por_sync #(.WIDTH(3), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (ext_rst_n),
    .d     (raw_in),
    .q     (sync_out)
  );

  assign {ext_s, sup_s, osc_s} = sync_out;
  assign cond_s = ext_s && sup_s && osc_s;
  assign dly_en = (st_q == SEQ_HOLD) && cond_s;

  por_delay_cnt #(.LIMIT(DELAY_CYC), .W(CNT_W)) u_dly (
    .clk   (clk),
    .rst_n (ext_rst_n),
    .en    (dly_en),
    .done  (dly_done),
    .cnt   (dly_cnt)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SEQ_HOLD: if (dly_done) st_d = SEQ_LIVE;
      SEQ_LIVE: if (!cond_s)  st_d = SEQ_HOLD;
      default:                st_d = SEQ_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge ext_rst_n) begin
    if (!ext_rst_n) st_q <= SEQ_HOLD;
    else            st_q <= st_d;
  end

  assign core_rst_n  = (st_q == SEQ_LIVE);
  assign rst_pin_lvl = (st_q == SEQ_LIVE);
  assign rst_pin_oe  = !ext_s || (st_q == SEQ_LIVE);
  assign if_float    = (st_q != SEQ_LIVE);

  // R2: release happens only on the edge after the counter reaches its last value
  a_r2_release_on_count: assert property (@(posedge clk) disable iff (!ext_rst_n)
    $rose(core_rst_n) |-> $past(dly_done));

  // R3, R8: a missing condition holds or reasserts reset by the next edge
  a_r3_hold_without_cond: assert property (@(posedge clk) disable iff (!ext_rst_n)
    !cond_s |=> !core_rst_n);

  // R6: once released the delay counter sits idle at zero
  a_r6_cnt_idle_live: assert property (@(posedge clk) disable iff (!ext_rst_n)
    core_rst_n |-> (dly_cnt == '0));

  // R7: a bus reset never pulls down a released reset while conditions hold
  a_r7_bus_reset_ignored: assert property (@(posedge clk) disable iff (!ext_rst_n)
    (usb_bus_rst && core_rst_n && cond_s) |=> core_rst_n);

  // R5: while the synchronised external reset is high and reset is held, pin floats
  a_r5_pin_float_wait: assert property (@(posedge clk) disable iff (!ext_rst_n)
    (ext_s && !core_rst_n) |-> !rst_pin_oe);
endmodule

// File: tb/sim_por_reset_seq.sv
module sim_por_reset_seq;
  localparam int CLK_HZ   = 100_000;
  localparam int DELAY_US = 5000;
  localparam int D        = (CLK_HZ / 1000) * DELAY_US / 1000;

  logic clk = 1'b0;
  logic ext_rst_n, supply_ok, osc_run, usb_bus_rst;
  logic core_rst_n, rst_pin_lvl, rst_pin_oe, if_float;
  int   n_chk = 0;
  int   n_bad = 0;
  int   cyc   = 0;
  int   seed  = 32'h5eed_1234;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  por_reset_seq #(.CLK_HZ(CLK_HZ), .DELAY_US(DELAY_US)) u0 (
    .clk(clk), .ext_rst_n(ext_rst_n), .supply_ok(supply_ok), .osc_run(osc_run),
    .usb_bus_rst(usb_bus_rst), .core_rst_n(core_rst_n), .rst_pin_lvl(rst_pin_lvl),
    .rst_pin_oe(rst_pin_oe), .if_float(if_float)
  );

  function automatic logic [3:0] exp_outs(input bit held, input bit ext_low);
    // {core_rst_n, oe, lvl, float}
    if (!held)        return 4'b1110;
    else if (ext_low) return 4'b0101;
    else              return 4'b0001;
  endfunction

  function automatic int exp_release();
    return D + 2;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] outs();
    return {core_rst_n, rst_pin_oe, rst_pin_lvl, if_float};
  endfunction

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      usb_bus_rst = 1'($urandom(seed) & 1);
      seed = seed + 1;
    end
  endtask

  task automatic wait_level(input logic lvl, output int n);
    n = 0;
    while (core_rst_n !== lvl && n < 3 * D) begin
      @(posedge clk);
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    int n;
    bit stayed;
    ext_rst_n = 1'b0; supply_ok = 1'b0; osc_run = 1'b0; usb_bus_rst = 1'b0;
    step(4);
    chk("R1 reset state", int'(outs()), int'(exp_outs(1, 1)));

    // R5: external reset high, supply and oscillator absent
    ext_rst_n = 1'b1;
    step(D + 10);
    chk("R5 pin floats while waiting", int'(outs()), int'(exp_outs(1, 0)));

    // R3: each single condition missing
    for (int m = 0; m < 3; m++) begin
      ext_rst_n = (m != 0); supply_ok = (m != 1); osc_run = (m != 2);
      stayed = 1;
      for (int i = 0; i < D + 10; i++) begin
        step(1);
        if (core_rst_n) stayed = 0;
      end
      chk($sformatf("R3 held with condition %0d missing", m), int'(stayed), 1);
      chk("R3 R1 outputs while held", int'(outs()), int'(exp_outs(1, m == 0)));
    end

    // R2, R6: clean simultaneous release
    ext_rst_n = 1'b0; supply_ok = 1'b0; osc_run = 1'b0;
    step(3);
    ext_rst_n = 1'b1; supply_ok = 1'b1; osc_run = 1'b1;
    wait_level(1'b1, n);
    chk("R2 release latency", n, exp_release());
    chk("R6 released outputs", int'(outs()), int'(exp_outs(0, 0)));

    // R7: bus reset toggled after release
    stayed = 1;
    for (int i = 0; i < 60; i++) begin
      usb_bus_rst = ~usb_bus_rst;
      @(posedge clk); @(negedge clk);
      if (outs() !== exp_outs(0, 0)) stayed = 0;
    end
    chk("R7 bus reset ignored after release", int'(stayed), 1);

    // R8: oscillator loss after release
    osc_run = 1'b0;
    wait_level(1'b0, n);
    chk("R8 reassert latency", n, 3);
    chk("R8 R5 outputs after loss", int'(outs()), int'(exp_outs(1, 0)));
    step(5);

    // R4: random drops during the count
    for (int it = 0; it < 8; it++) begin
      int k, len;
      bit which;
      k = 5 + int'($urandom(seed) % (D - 10)); seed = seed + 7;
      len = 1 + int'($urandom(seed) % 20);    seed = seed + 7;
      which = 1'($urandom(seed) & 1);          seed = seed + 7;
      supply_ok = 1'b1; osc_run = 1'b1;
      step(k);
      chk("R4 still held before drop", int'(core_rst_n), 0);
      if (which) supply_ok = 1'b0; else osc_run = 1'b0;
      step(len);
      supply_ok = 1'b1; osc_run = 1'b1;
      wait_level(1'b1, n);
      chk($sformatf("R4 restart latency k=%0d len=%0d", k, len), n, exp_release());
      supply_ok = 1'b0;
      step(6);
    end

    // R9: asynchronous external reset after release
    supply_ok = 1'b1; osc_run = 1'b1;
    wait_level(1'b1, n);
    chk("R9 released before test", int'(core_rst_n), 1);
    @(posedge clk); #3;
    ext_rst_n = 1'b0;
    #1;
    chk("R9 R1 immediate assertion", int'(outs()), int'(exp_outs(1, 1)));
    @(negedge clk);
    step(3);
    chk("R7 R1 held with bus reset toggling", int'(outs()), int'(exp_outs(1, 1)));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule